// File: doc/BRIEF.md
# LCD Controller Register Interface

This block is the software-visible register file of a colour LCD controller. It sits on a simple 32-bit peripheral bus that spans 4 KB. Software uses it to program the panel timing words, the frame base addresses for the upper and lower panel halves, a control word and an interrupt mask. The block decodes those registers into the values the display engine uses: panel width and height, an enable flag, a pixel depth code, and the byte-order and colour-swap flags.

Four event inputs from the display engine latch into a status register. Software reads that register raw or masked and clears bits with a write-one-to-clear access. The interrupt line is high while any masked status bit is set.

A window of the address map is passed through a port to palette storage that lives outside this block. A fixed set of identification bytes sits at the top of the map. A strap input selects one of two map variants. The variants differ in the identification bytes, and they swap the word offsets of the control and mask registers.

Top module: `lcdc_regs`

## Requirements
- R1: After reset every register and status bit is zero. The block therefore shows width 16, height 1, enabled low, depth code 0 and irq low.
- R2: Word offsets 0 to 3 (address bits [11:2]) hold timing words 0 to 3. Offset 4 holds the upper base and offset 5 the lower base. All six are read/write over 32 bits, and the upper and lower bases are driven on their own outputs. Read data appears on `rdata_o` one cycle after the request and holds until the next read.
- R3: `width_o` equals ((timing0 & 0xFC) + 4) * 4. `height_o` equals (timing1 & 0x3FF) + 1.
- R4: The control word is 32-bit read/write and its fields are decoded as follows:
  - `bpp_o` is control bits [3:1].
  - `bgr_o` is bit 8.
  - `be_byte_o` is bit 9.
  - `be_pix_o` is bit 10.
  - `enabled_o` is high only when bit 0 and bit 11 are both set.
- R5: With `variant_i` = 0 the control word is at offset 6 and the mask at offset 7. With `variant_i` = 1 the two offsets are swapped.
- R6: A high on event input bit n sets status bit n. Offset 8 reads the raw status and offset 9 reads status AND mask. Both are zero-extended from 4 bits, and the mask holds 4 bits.
- R7: A write to offset 10 clears each status bit whose data bit is 1. An event arriving in the same cycle as the clear wins.
- R8: `irq_o` is high exactly when status AND mask is non-zero, as seen from the registers after each clock edge.
- R9: Reads in 0xFE0 to 0xFFF return one identification byte per word, in bits [7:0]:
  - Variant 0 returns 0x10,0x11,0x04,0x00,0x0D,0xF0,0x05,0xB1.
  - Variant 1 returns 0x11,0x11,0x24,0x00,0x0D,0xF0,0x05,0xB1.
- R10: Accesses in 0x200 to 0x3FF are forwarded to the palette port with index (address - 0x200) >> 2. Writes pass the data through, reads return `pal_rdata_i`, and neither flags an error.
- R11: Every other access reads zero, changes no state and pulses `err_o` for one cycle. This covers:
  - any address outside the defined regions;
  - a read of offset 10;
  - a write to offset 8 or 9;
  - a write to the identification range.

  Defined accesses never raise `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| variant_i | input | 1 | Register-map variant strap |
| req_i | input | 1 | Bus access request, one cycle per access |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| err_o | output | 1 | One-cycle pulse for an undefined access |
| pal_sel_o | output | 1 | Palette window access |
| pal_we_o | output | 1 | Palette write |
| pal_idx_o | output | 7 | Palette word index |
| pal_wdata_o | output | 32 | Palette write data |
| pal_rdata_i | input | 32 | Palette read data, same cycle |
| evt_i | input | 4 | Status-setting events |
| irq_o | output | 1 | Masked interrupt |
| upbase_o | output | 32 | Upper panel base address |
| lpbase_o | output | 32 | Lower panel base address |
| width_o | output | 11 | Panel width in pixels |
| height_o | output | 11 | Panel height in lines |
| enabled_o | output | 1 | Display enabled |
| bpp_o | output | 3 | Pixel depth code |
| bgr_o | output | 1 | Red/blue swap |
| be_byte_o | output | 1 | Big-endian byte order |
| be_pix_o | output | 1 | Big-endian pixel order within a byte |

## Verification
The properties assume that the variant strap only changes while no request is in flight. The bench flips it only between idle accesses. The properties also assume that a bus request lasts a single cycle; every bench access drives `req_i` for exactly one cycle and then leaves it low for at least one cycle. The random phase mixes register, palette, identification and unmapped addresses with random events, so set-versus-clear collisions and masked interrupts occur on their own. Directed accesses add the extreme geometry values, every identification byte in both variants, and a clear that lands in the same cycle as an event.

// File: rtl/lcdc_regs.sv
module lcdc_regs #(
  parameter int NEVT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            variant_i,
  input  logic            req_i,
  input  logic            wr_i,
  input  logic [11:0]     addr_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  output logic            err_o,
  output logic            pal_sel_o,
  output logic            pal_we_o,
  output logic [6:0]      pal_idx_o,
  output logic [31:0]     pal_wdata_o,
  input  logic [31:0]     pal_rdata_i,
  input  logic [NEVT-1:0] evt_i,
  output logic            irq_o,
  output logic [31:0]     upbase_o,
  output logic [31:0]     lpbase_o,
  output logic [10:0]     width_o,
  output logic [10:0]     height_o,
  output logic            enabled_o,
  output logic [2:0]      bpp_o,
  output logic            bgr_o,
  output logic            be_byte_o,
  output logic            be_pix_o
);

  localparam logic [9:0] OFF_RAW = 10'd8;
  localparam logic [9:0] OFF_MSK = 10'd9;
  localparam logic [9:0] OFF_CLR = 10'd10;

  logic [31:0]     tim_q [4];
  logic [31:0]     up_q, lp_q, ctrl_q;
  logic [NEVT-1:0] mask_q, stat_q;

  wire [9:0] wo      = addr_i[11:2];
  wire       is_pal  = addr_i[11:9] == 3'b001;
  wire       is_id   = addr_i[11:5] == 7'h7F;
  wire [9:0] ctrl_wo = variant_i ? 10'd7 : 10'd6;
  wire [9:0] mask_wo = variant_i ? 10'd6 : 10'd7;

  function automatic logic [7:0] id_byte(input logic v, input logic [2:0] i);
    case (i)
      3'd0:    id_byte = v ? 8'h11 : 8'h10;
      3'd1:    id_byte = 8'h11;
      3'd2:    id_byte = v ? 8'h24 : 8'h04;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  logic        hit;
  logic [31:0] rd_val;

  always_comb begin
    hit    = 1'b1;
    rd_val = '0;
    if (is_pal) begin
      rd_val = pal_rdata_i;
    end else if (is_id) begin
      hit    = !wr_i;
      rd_val = {24'h0, id_byte(variant_i, addr_i[4:2])};
    end else begin
      case (wo)
        10'd0, 10'd1, 10'd2, 10'd3: rd_val = tim_q[wo[1:0]];
        10'd4:   rd_val = up_q;
        10'd5:   rd_val = lp_q;
        10'd6, 10'd7: rd_val = (wo == ctrl_wo) ? ctrl_q : 32'(mask_q);
        OFF_RAW: begin hit = !wr_i; rd_val = 32'(stat_q); end
        OFF_MSK: begin hit = !wr_i; rd_val = 32'(stat_q & mask_q); end
        OFF_CLR: hit = wr_i;
        default: hit = 1'b0;
      endcase
    end
  end

  wire             do_wr = req_i && wr_i && hit && !is_pal && !is_id;
  wire [NEVT-1:0]  clr   = (do_wr && wo == OFF_CLR) ? wdata_i[NEVT-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) tim_q[i] <= '0;
      up_q    <= '0;
      lp_q    <= '0;
      ctrl_q  <= '0;
      mask_q  <= '0;
      stat_q  <= '0;
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      if (do_wr) begin
        if (wo < 10'd4)        tim_q[wo[1:0]] <= wdata_i;
        else if (wo == 10'd4)  up_q <= wdata_i;
        else if (wo == 10'd5)  lp_q <= wdata_i;
        else if (wo == ctrl_wo) ctrl_q <= wdata_i;
        else if (wo == mask_wo) mask_q <= wdata_i[NEVT-1:0];
      end
      stat_q <= (stat_q & ~clr) | evt_i;
      if (req_i && !wr_i) rdata_o <= hit ? rd_val : '0;
      err_o <= req_i && !hit;
    end
  end

  assign pal_sel_o   = req_i && is_pal;
  assign pal_we_o    = req_i && is_pal && wr_i;
  assign pal_idx_o   = addr_i[8:2];
  assign pal_wdata_o = wdata_i;

  assign irq_o     = |(stat_q & mask_q);
  assign upbase_o  = up_q;
  assign lpbase_o  = lp_q;
  assign width_o   = {7'(tim_q[0][7:2]) + 7'd1, 4'b0000};
  assign height_o  = 11'(tim_q[1][9:0]) + 11'd1;
  assign enabled_o = ctrl_q[0] && ctrl_q[11];
  assign bpp_o     = ctrl_q[3:1];
  assign bgr_o     = ctrl_q[8];
  assign be_byte_o = ctrl_q[9];
  assign be_pix_o  = ctrl_q[10];

endmodule

// File: rtl/lcdc_regs_chk.sv
module lcdc_regs_chk #(
  parameter int NEVT = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            variant_i,
  input logic            req_i,
  input logic            wr_i,
  input logic [11:0]     addr_i,
  input logic [31:0]     wdata_i,
  input logic            err_o,
  input logic [NEVT-1:0] evt_i,
  input logic            irq_o,
  input logic            enabled_o,
  input logic [10:0]     height_o,
  input logic [NEVT-1:0] mask_q
);

  wire [9:0] wo = addr_i[11:2];

  assert_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && wr_i && wo == (variant_i ? 10'd7 : 10'd6)
    |=> enabled_o == ($past(wdata_i[0]) && $past(wdata_i[11])));

  assert_height_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && wr_i && wo == 10'd1
    |=> height_o == 11'($past(wdata_i[9:0])) + 11'd1);

  assert_no_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && wo < 10'd6 |=> !err_o);

  assert_err_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !err_o);

  assert_evt_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & mask_q)) && !(req_i && wr_i) |=> irq_o);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && wr_i && wo == 10'd10 && (&wdata_i[NEVT-1:0]) && evt_i == '0
    |=> !irq_o);

endmodule

bind lcdc_regs lcdc_regs_chk #(.NEVT(NEVT)) u_chk (
  .clk(clk), .rst_n(rst_n), .variant_i(variant_i), .req_i(req_i),
  .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i), .err_o(err_o),
  .evt_i(evt_i), .irq_o(irq_o), .enabled_o(enabled_o),
  .height_o(height_o), .mask_q(mask_q)
);

// File: tb/lcdc_regs_tb.sv
`timescale 1ns/1ps
module lcdc_regs_tb;
  logic clk = 0, rst_n = 0, variant = 0;
  logic req = 0, wr = 0;
  logic [11:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic err, pal_sel, pal_we, irq, enabled, bgr, be_byte, be_pix;
  logic [6:0] pal_idx;
  logic [31:0] pal_wdata, upbase, lpbase;
  logic [3:0] evt = 0;
  logic [10:0] width, height;
  logic [2:0] bpp;
  logic [31:0] pal_mem [128];

  always #2 clk = ~clk;

  lcdc_regs u_dut (
    .clk(clk), .rst_n(rst_n), .variant_i(variant), .req_i(req), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .err_o(err),
    .pal_sel_o(pal_sel), .pal_we_o(pal_we), .pal_idx_o(pal_idx),
    .pal_wdata_o(pal_wdata), .pal_rdata_i(pal_mem[pal_idx]),
    .evt_i(evt), .irq_o(irq), .upbase_o(upbase), .lpbase_o(lpbase),
    .width_o(width), .height_o(height), .enabled_o(enabled), .bpp_o(bpp),
    .bgr_o(bgr), .be_byte_o(be_byte), .be_pix_o(be_pix)
  );

  always @(posedge clk) if (pal_sel && pal_we) pal_mem[pal_idx] <= pal_wdata;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_tim [4];
  logic [31:0] m_up, m_lp, m_ctrl;
  logic [3:0]  m_mask, m_stat;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_id(logic v, int i);
    logic [7:0] t [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    if (v && i == 0) return 8'h11;
    if (v && i == 2) return 8'h24;
    return t[i];
  endfunction

  function automatic string tag_of(logic [11:0] a);
    int w = int'(a[11:2]);
    if (a >= 12'h200 && a < 12'h400) return "R10";
    if (a >= 12'hFE0) return "R9";
    if (w <= 5) return "R2";
    if (w <= 7) return "R5";
    if (w <= 9) return "R6";
    if (w == 10) return "R7";
    return "R11";
  endfunction

  // returns {hit, value}
  function automatic logic [32:0] mread(logic w, logic [11:0] a);
    int o = int'(a[11:2]);
    int c = variant ? 7 : 6;
    if (a >= 12'h200 && a < 12'h400) return {1'b1, w ? 32'h0 : pal_mem[a[8:2]]};
    if (a >= 12'hFE0) return w ? 33'h0 : {1'b1, 24'h0, exp_id(variant, int'(a[4:2]))};
    if (o < 4) return {1'b1, m_tim[o]};
    if (o == 4) return {1'b1, m_up};
    if (o == 5) return {1'b1, m_lp};
    if (o == c) return {1'b1, m_ctrl};
    if (o == 6 || o == 7) return {1'b1, 28'h0, m_mask};
    if (o == 8) return w ? 33'h0 : {1'b1, 28'h0, m_stat};
    if (o == 9) return w ? 33'h0 : {1'b1, 28'h0, m_stat & m_mask};
    if (o == 10) return w ? {1'b1, 32'h0} : 33'h0;
    return 33'h0;
  endfunction

  task automatic chk_outs();
    chk("R3 width", 32'(width), ((m_tim[0] & 32'hFC) + 4) * 4);
    chk("R3 height", 32'(height), (m_tim[1] & 32'h3FF) + 1);
    chk("R4 enabled", 32'(enabled), 32'(m_ctrl[0] & m_ctrl[11]));
    chk("R4 fields", {bpp, bgr, be_byte, be_pix}, {m_ctrl[3:1], m_ctrl[8], m_ctrl[9], m_ctrl[10]});
    chk("R8 irq", 32'(irq), 32'(|(m_stat & m_mask)));
    chk("R2 bases", upbase ^ {lpbase[15:0], lpbase[31:16]}, m_up ^ {m_lp[15:0], m_lp[31:16]});
  endtask

  logic [31:0] last_rd = 0;

  task automatic acc(logic w, logic [11:0] a, logic [31:0] d, logic [3:0] ev);
    logic [32:0] e;
    int o;
    @(negedge clk);
    req = 1; wr = w; addr = a; wdata = d; evt = ev;
    e = mread(w, a);
    o = int'(a[11:2]);
    @(posedge clk);
    if (e[32] && w && !(a >= 12'h200 && a < 12'h400) && a < 12'hFE0) begin
      if (o < 4) m_tim[o] = d;
      else if (o == 4) m_up = d;
      else if (o == 5) m_lp = d;
      else if (o == (variant ? 7 : 6)) m_ctrl = d;
      else if (o == 6 || o == 7) m_mask = d[3:0];
      else if (o == 10) m_stat = m_stat & ~d[3:0];
    end
    m_stat = m_stat | ev;
    @(negedge clk);
    req = 0; evt = 0;
    chk({tag_of(a), e[32] ? "" : " R11"}, 32'(err), 32'(!e[32]));
    if (!w) begin
      last_rd = e[32] ? e[31:0] : 32'h0;
      chk(tag_of(a), rdata, last_rd);
    end else begin
      chk("R2 rdata hold", rdata, last_rd);
    end
    chk_outs();
  endtask

  function automatic logic [11:0] rand_addr();
    int k = int'($urandom_range(0, 9));
    if (k < 6) return {$urandom_range(0, 11), 2'b00};
    if (k < 8) return 12'h200 + 12'({$urandom_range(0, 127), 2'b00});
    if (k < 9) return 12'hFE0 + 12'({$urandom_range(0, 7), 2'b00});
    return 12'($urandom);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1));
    for (int i = 0; i < 128; i++) pal_mem[i] = 32'(i * 7);
    for (int i = 0; i < 4; i++) m_tim[i] = 0;
    m_up = 0; m_lp = 0; m_ctrl = 0; m_mask = 0; m_stat = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 width", 32'(width), 32'd16);
    chk("R1 height", 32'(height), 32'd1);
    chk("R1 enabled", 32'(enabled), 0);
    chk("R1 irq", 32'(irq), 0);
    acc(0, 12'h000, 0, 0);
    // R3 geometry corners
    acc(1, 12'h000, 32'hFFFF_FFFF, 0);
    acc(1, 12'h004, 32'h0000_03FF, 0);
    acc(1, 12'h000, 32'h0000_0003, 0);
    acc(1, 12'h004, 32'h0000_0400, 0);
    // R4 enable needs both bits; R5 variant 0 map
    acc(1, 12'h018, 32'h0000_0001, 0);
    acc(1, 12'h018, 32'h0000_0801, 0);
    acc(1, 12'h01C, 32'h0000_000F, 0);
    // R6/R7/R8 events, masked read, clear with colliding event
    acc(0, 12'h020, 0, 4'b0101);
    acc(0, 12'h024, 0, 0);
    acc(1, 12'h028, 32'hF, 4'b0100);
    acc(1, 12'h028, 32'hF, 0);
    // R11 undefined accesses
    acc(0, 12'h028, 0, 0);
    acc(1, 12'h020, 32'hF, 0);
    acc(1, 12'hFE0, 32'h1, 0);
    acc(0, 12'h100, 0, 0);
    acc(0, 12'hFDC, 0, 0);
    // R9 identification bytes, both variants; R5 swapped map
    for (int i = 0; i < 8; i++) acc(0, 12'hFE0 + 12'(i * 4), 0, 0);
    @(negedge clk); variant = 1;
    for (int i = 0; i < 8; i++) acc(0, 12'hFE0 + 12'(i * 4), 0, 0);
    acc(0, 12'h01C, 0, 0);
    acc(0, 12'h018, 0, 0);
    acc(1, 12'h01C, 32'h0000_0E00, 0);
    // R10 palette write then read
    acc(1, 12'h3FC, 32'hCAFE_0001, 0);
    acc(0, 12'h3FC, 0, 0);
    // random mix
    for (int i = 0; i < 1500; i++) begin
      if (i == 750) begin @(negedge clk); variant = 0; end
      acc($urandom_range(0, 1) == 1, rand_addr(), $urandom,
          ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule